// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one load request from a group of 32 lanes and turns it into the smallest set of aligned memory transactions that serves it. Each lane supplies a byte address and an active bit, and every lane reads one 4-byte word. The block groups the active lanes by the 128-byte aligned segment their word falls in. For each segment it picks the smallest aligned block of 32, 64 or 128 bytes that still holds every word touched there. Each transaction goes out with its aligned base address, its size in bytes and a mask of the lanes it serves.

Transactions are offered one at a time on a valid/grant handshake, lowest address first. When the last one is granted, a one-cycle completion pulse reports three totals for the request: how many transactions it took, how many bytes the lanes asked for, and how many bytes were fetched. The ratio of the last two gives the efficiency of the access pattern. The block takes a new request only after the current one has completed.

Top module: `wmc_coalescer`

## Requirements
- R1: A request whose active lanes all read consecutive words starting at a 128-byte aligned base is served by exactly one 128-byte transaction, and its lane mask holds every active lane.
- R2: Every transaction serves exactly the active, not yet served lanes whose word lies in the range from its base address up to its base plus its size. Lane mask bit k stands for lane k, and each active lane is served once.
- R3: A transaction's size is 32, 64 or 128 bytes, and its base is a multiple of its size. Within a 128-byte segment, the size is the smallest of these whose aligned block covers every touched 32-byte sector of that segment. A segment whose touched sectors are 1 and 2 therefore takes 128 bytes.
- R4: Transactions go out in strictly ascending base address. The next one is shown only after the current one is granted. While `txn_valid` is high and `txn_grant` is low, the address, size and lane mask hold steady.
- R5: Inactive lanes add neither addresses nor bytes. A request with no active lane completes with zero transactions.
- R6: `done` is high for exactly one cycle: the cycle after the clock edge that grants the last transaction, or for an empty request the cycle after the edge following acceptance. With it, `done_txns` gives the transaction count, `done_useful` gives 4 times the number of active lanes, and `done_fetched` gives the sum of the transaction sizes.
- R7: `req_ready` is low from the edge that accepts a request until `done` rises. A `req_valid` raised during that time is ignored and does not change the request in progress.
- R8: After reset `req_ready` is high, and `txn_valid` and `done` are low.
- R9: The two lowest bits of each lane address are ignored, so each lane reads the aligned word that holds its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | 1024 | Lane byte addresses, lane k at bits 32k+31:32k |
| req_active | input | 32 | Active bit for each lane, bit k for lane k |
| txn_valid | output | 1 | A transaction is offered |
| txn_grant | input | 1 | Memory side takes the offered transaction |
| txn_addr | output | 32 | Aligned transaction base address |
| txn_size | output | 8 | Transaction size in bytes: 32, 64 or 128 |
| txn_lanes | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle completion pulse |
| done_txns | output | 6 | Transactions issued for the request |
| done_useful | output | 8 | Bytes requested by the active lanes |
| done_fetched | output | 13 | Bytes moved by all transactions |

## Verification
The hardest situations to reach from the ports are these: a segment whose touched sectors straddle the 64-byte midpoint, a descending-stride request whose lowest address belongs to the last lane, and a long request that sees a stalled grant and a second request offered partway through. The stimulus builds each lane address as a base plus a signed stride, masked by the active bits. The bench uses that to place words on chosen sector boundaries and to reverse the order of the lanes. For odd-numbered vectors the grant is withheld in a repeating cycle pattern, and during the 32-transaction case a new request is offered while the block is busy. For every transaction the bench works out its own expected lane mask from the address ranges and compares it with `txn_lanes`.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

  // Smallest power-of-two group level whose aligned group holds both sector indices.
  function automatic int unsigned cover_level(input int unsigned lo, input int unsigned hi);
    int unsigned lvl;
    logic        hit;
    lvl = 0;
    hit = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!hit && ((lo >> i) == (hi >> i))) begin
        lvl = i;
        hit = 1'b1;
      end
    end
    return lvl;
  endfunction

  function automatic int unsigned count_ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/wmc_seg_select.sv
module wmc_seg_select #(
  parameter int LANES = 32,
  parameter int SEG_W = 25
) (
  input  logic [LANES*SEG_W-1:0] lane_seg,
  input  logic [LANES-1:0]       pending,
  output logic [SEG_W-1:0]       seg_id,
  output logic [LANES-1:0]       seg_lanes
);

  logic [SEG_W-1:0] seg_of [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign seg_of[g] = lane_seg[g*SEG_W +: SEG_W];
  end

  // Lowest segment number among lanes still waiting.
  always_comb begin
    logic found;
    found  = 1'b0;
    seg_id = '1;
    for (int i = 0; i < LANES; i++) begin
      if (pending[i] && (!found || (seg_of[i] < seg_id))) begin
        seg_id = seg_of[i];
        found  = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_match
    assign seg_lanes[g] = pending[g] && (seg_of[g] == seg_id);
  end

endmodule

// File: rtl/wmc_span.sv
module wmc_span
  import wmc_pkg::*;
#(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 32,
  parameter int SEG_SH  = 7,
  parameter int SECT_SH = 5,
  parameter int SIZE_W  = 8,
  localparam int SEG_W  = ADDR_W - SEG_SH,
  localparam int SC_W   = SEG_SH - SECT_SH,
  localparam int NSECT  = 1 << SC_W
) (
  input  logic [LANES*SC_W-1:0] lane_sect,
  input  logic [LANES-1:0]      seg_lanes,
  input  logic [SEG_W-1:0]      seg_id,
  output logic [ADDR_W-1:0]     txn_addr,
  output logic [SIZE_W-1:0]     txn_size
);

  logic [NSECT-1:0] touched;
  int unsigned      lo_s, hi_s, lvl;
  logic [SEG_SH-1:0] offs;

  always_comb begin
    touched = '0;
    for (int i = 0; i < LANES; i++)
      if (seg_lanes[i]) touched[lane_sect[i*SC_W +: SC_W]] = 1'b1;
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    lo_s = 0;
    hi_s = 0;
    for (int s = 0; s < NSECT; s++) begin
      if (touched[s]) begin
        if (!seen) lo_s = s;
        hi_s = s;
        seen = 1'b1;
      end
    end
  end

  always_comb begin
    lvl      = cover_level(lo_s, hi_s);
    offs     = SEG_SH'(((lo_s >> lvl) << lvl) << SECT_SH);
    txn_size = SIZE_W'(32'd1 << (SECT_SH + lvl));
    txn_addr = {seg_id, offs};
  end

endmodule

// File: rtl/wmc_coalescer.sv
module wmc_coalescer
  import wmc_pkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int WORD_BYTES   = 4,
  parameter int SECTOR_BYTES = 32,
  parameter int SEG_BYTES    = 128,
  localparam int SEG_SH  = $clog2(SEG_BYTES),
  localparam int SECT_SH = $clog2(SECTOR_BYTES),
  localparam int SEG_W   = ADDR_W - SEG_SH,
  localparam int SC_W    = SEG_SH - SECT_SH,
  localparam int SIZE_W  = SEG_SH + 1,
  localparam int CNT_W   = $clog2(LANES) + 1,
  localparam int USE_W   = $clog2(LANES*WORD_BYTES) + 1,
  localparam int FET_W   = $clog2(LANES*SEG_BYTES) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_active,
  output logic                    txn_valid,
  input  logic                    txn_grant,
  output logic [ADDR_W-1:0]       txn_addr,
  output logic [SIZE_W-1:0]       txn_size,
  output logic [LANES-1:0]        txn_lanes,
  output logic                    done,
  output logic [CNT_W-1:0]        done_txns,
  output logic [USE_W-1:0]        done_useful,
  output logic [FET_W-1:0]        done_fetched
);

  // Captured request: per lane, segment number and sector within the segment.
  logic [LANES*SEG_W-1:0]   seg_in, seg_q;
  logic [LANES*SC_W-1:0]    sect_in, sect_q;
  logic [LANES*SECT_SH-1:0] offs_unused;
  logic [LANES-1:0]         pend_q;
  logic                     busy_q, done_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [USE_W-1:0]         use_q;
  logic [FET_W-1:0]         fet_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign seg_in[g*SEG_W +: SEG_W]       = req_addr[g*ADDR_W + SEG_SH +: SEG_W];
    assign sect_in[g*SC_W +: SC_W]        = req_addr[g*ADDR_W + SECT_SH +: SC_W];
    assign offs_unused[g*SECT_SH +: SECT_SH] = req_addr[g*ADDR_W +: SECT_SH];
  end

  // Named events, also watched by the bound checker.
  logic             req_fire, grant_fire, finish;
  logic [SEG_W-1:0] sel_seg;
  logic [LANES-1:0] sel_lanes, remain;

  wmc_seg_select #(.LANES(LANES), .SEG_W(SEG_W)) u_select (
    .lane_seg (seg_q),
    .pending  (pend_q),
    .seg_id   (sel_seg),
    .seg_lanes(sel_lanes)
  );

  wmc_span #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_SH(SEG_SH),
    .SECT_SH(SECT_SH), .SIZE_W(SIZE_W)
  ) u_span (
    .lane_sect(sect_q),
    .seg_lanes(sel_lanes),
    .seg_id   (sel_seg),
    .txn_addr (txn_addr),
    .txn_size (txn_size)
  );

  assign req_ready  = ~busy_q;
  assign req_fire   = req_valid & req_ready;
  assign txn_valid  = busy_q & (|pend_q);
  assign txn_lanes  = sel_lanes;
  assign grant_fire = txn_valid & txn_grant;
  assign remain     = pend_q & ~sel_lanes;
  assign finish     = busy_q & (~(|pend_q) | (grant_fire & ~(|remain)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      seg_q  <= '0;
      sect_q <= '0;
      cnt_q  <= '0;
      use_q  <= '0;
      fet_q  <= '0;
    end else begin
      done_q <= finish;
      if (req_fire) begin
        busy_q <= 1'b1;
        pend_q <= req_active;
        seg_q  <= seg_in;
        sect_q <= sect_in;
        cnt_q  <= '0;
        fet_q  <= '0;
        use_q  <= USE_W'(count_ones(64'(req_active)) * WORD_BYTES);
      end
      if (grant_fire) begin
        pend_q <= remain;
        cnt_q  <= cnt_q + CNT_W'(1);
        fet_q  <= fet_q + FET_W'(txn_size);
      end
      if (finish) busy_q <= 1'b0;
    end
  end

  assign done         = done_q;
  assign done_txns    = cnt_q;
  assign done_useful  = use_q;
  assign done_fetched = fet_q;

endmodule

// File: rtl/wmc_coalescer_chk.sv
module wmc_coalescer_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 32,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_fire,
  input logic              grant_fire,
  input logic              finish,
  input logic              req_ready,
  input logic              txn_valid,
  input logic              txn_grant,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [SIZE_W-1:0] txn_size,
  input logic [LANES-1:0]  txn_lanes,
  input logic              done,
  input logic [CNT_W-1:0]  done_txns
);

  logic [ADDR_W-1:0] last_addr;
  logic              have_last;
  logic [CNT_W-1:0]  grants_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr <= '0;
      have_last <= 1'b0;
      grants_q  <= '0;
    end else if (req_fire) begin
      have_last <= 1'b0;
      grants_q  <= '0;
    end else if (grant_fire) begin
      have_last <= 1'b1;
      last_addr <= txn_addr;
      grants_q  <= grants_q + CNT_W'(1);
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_grant |=> txn_valid && $stable(txn_addr) && $stable(txn_size) && $stable(txn_lanes));

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && have_last |-> txn_addr > last_addr);

  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ($countones(txn_size) == 1) && ((txn_addr & ADDR_W'(txn_size - 1'b1)) == '0));

  assert_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_lanes != '0);

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done && req_ready);

  assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_txns == grants_q);

endmodule

bind wmc_coalescer wmc_coalescer_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_fire  (req_fire),
  .grant_fire(grant_fire),
  .finish    (finish),
  .req_ready (req_ready),
  .txn_valid (txn_valid),
  .txn_grant (txn_grant),
  .txn_addr  (txn_addr),
  .txn_size  (txn_size),
  .txn_lanes (txn_lanes),
  .done      (done),
  .done_txns (done_txns)
);

// File: tb/wmc_coalescer_tb.sv
module wmc_coalescer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int ADDR_W = 32;
  localparam int NV     = 12;

  logic                    clk, rst_n;
  logic                    req_valid, req_ready;
  logic [LANES*ADDR_W-1:0] req_addr;
  logic [LANES-1:0]        req_active;
  logic                    txn_valid, txn_grant;
  logic [ADDR_W-1:0]       txn_addr;
  logic [7:0]              txn_size;
  logic [LANES-1:0]        txn_lanes;
  logic                    done;
  logic [5:0]              done_txns;
  logic [7:0]              done_useful;
  logic [12:0]             done_fetched;

  int n_chk  = 0;
  int n_fail = 0;

  wmc_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_active(req_active), .txn_valid(txn_valid),
    .txn_grant(txn_grant), .txn_addr(txn_addr), .txn_size(txn_size),
    .txn_lanes(txn_lanes), .done(done), .done_txns(done_txns),
    .done_useful(done_useful), .done_fetched(done_fetched)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector table: lane k reads base + stride*k when active.
  //  0 R1 aligned unit stride     1 R2 misaligned unit stride   2 R2 stride 8 (50%)
  //  3 R2 stride 128, 32 txns     4 R5 lower half active        5 R3 one sector
  //  6 R5 upper half active       7 R5 no lane active           8 R3 sector 1 only
  //  9 R3 sectors 1 and 2 -> 128  10 R4 descending stride       11 R9 low bits ignored
  localparam logic [31:0] T_BASE   [NV] = '{32'h1000, 32'h1010, 32'h2000, 32'h0, 32'h3000, 32'h3020,
                                            32'h3000, 32'h5000, 32'h4030, 32'h4038, 32'h8F80, 32'h1003};
  localparam logic [31:0] T_STRIDE [NV] = '{4, 4, 8, 128, 4, 4, 4, 4, 4, 4, 32'hFFFF_FF80, 4};
  localparam logic [31:0] T_MASK   [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'h0000_FFFF, 32'h0000_00FF, 32'hFFFF_0000, 32'h0,
                                            32'h3, 32'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam int          T_CNT    [NV] = '{1, 2, 2, 32, 1, 1, 1, 0, 1, 1, 32, 1};
  localparam int          T_USE    [NV] = '{128, 128, 128, 128, 64, 32, 64, 0, 8, 16, 128, 128};
  localparam int          T_FET    [NV] = '{128, 160, 256, 1024, 64, 32, 64, 0, 32, 128, 1024, 128};
  localparam logic [31:0] T_FADDR  [NV] = '{32'h1000, 32'h1000, 32'h2000, 32'h0, 32'h3000, 32'h3020,
                                            32'h3040, 32'h0, 32'h4020, 32'h4000, 32'h8000, 32'h1000};
  localparam int          T_FSIZE  [NV] = '{128, 128, 128, 32, 64, 32, 64, 0, 32, 128, 32, 128};
  localparam logic [31:0] T_FLANES [NV] = '{32'hFFFF_FFFF, 32'h0FFF_FFFF, 32'h0000_FFFF, 32'h1,
                                            32'h0000_FFFF, 32'h0000_00FF, 32'hFFFF_0000, 32'h0,
                                            32'h3, 32'hF, 32'h8000_0000, 32'hFFFF_FFFF};

  function automatic string vec_tag(input int v);
    case (v)
      0:         return "R1";
      1, 2, 3:   return "R2";
      4, 6, 7:   return "R5";
      5, 8, 9:   return "R3";
      10:        return "R4";
      default:   return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_word(input int v, input int k);
    logic [31:0] a;
    a = T_BASE[v] + T_STRIDE[v] * 32'(k);
    return a & 32'hFFFF_FFFC;
  endfunction

  task automatic run_vec(input int v);
    logic [31:0] served, exp_lanes, last_addr, s_addr, s_lanes;
    logic [7:0]  s_size;
    bit          have_last, stalled, seen_first, got_done;
    int          ntx, fet;
    string       tg;
    tg = vec_tag(v);
    served = '0; have_last = 0; stalled = 0; seen_first = 0; got_done = 0;
    ntx = 0; fet = 0; last_addr = '0; s_addr = '0; s_lanes = '0; s_size = '0;
    @(negedge clk);
    for (int k = 0; k < LANES; k++) req_addr[k*ADDR_W +: ADDR_W] = T_BASE[v] + T_STRIDE[v] * 32'(k);
    req_active = T_MASK[v];
    req_valid  = 1'b1;
    chk(req_ready == 1'b1, "R7", "ready before request", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 400 && !got_done; cyc++) begin
      if (v == 3 && cyc >= 2 && cyc <= 4) begin
        req_valid  = 1'b1;
        req_active = 32'h1;
        chk(req_ready == 1'b0, "R7", "ready while busy", 32'(req_ready), 0);
      end else if (v == 3 && cyc == 5) begin
        req_valid  = 1'b0;
        req_active = T_MASK[v];
      end
      if (done) begin
        got_done = 1;
        chk(done_txns == 6'(T_CNT[v]), tg, "R6 done_txns", 32'(done_txns), T_CNT[v]);
        chk(done_useful == 8'(T_USE[v]), tg, "R6 done_useful", 32'(done_useful), T_USE[v]);
        chk(done_fetched == 13'(T_FET[v]), tg, "R6 done_fetched", 32'(done_fetched), T_FET[v]);
        chk(ntx == T_CNT[v], tg, "R6 grants seen", ntx, T_CNT[v]);
        chk(fet == T_FET[v], tg, "R6 bytes seen", fet, T_FET[v]);
        chk(served == T_MASK[v], "R2", "lanes served", served, T_MASK[v]);
        chk(req_ready == 1'b1, "R7", "ready at done", 32'(req_ready), 1);
        chk(txn_valid == 1'b0, "R6", "valid at done", 32'(txn_valid), 0);
        txn_grant = 1'b0;
      end else if (txn_valid) begin
        if (stalled) begin
          chk(txn_addr == s_addr && txn_size == s_size && txn_lanes == s_lanes, "R4",
              "held while stalled", txn_addr, s_addr);
        end else begin
          exp_lanes = '0;
          for (int k = 0; k < LANES; k++)
            if (T_MASK[v][k] && !served[k] && lane_word(v, k) >= txn_addr &&
                lane_word(v, k) < txn_addr + 32'(txn_size))
              exp_lanes[k] = 1'b1;
          chk(txn_lanes == exp_lanes, "R2", "lane mask", txn_lanes, exp_lanes);
          if (have_last) chk(txn_addr > last_addr, "R4", "ascending", txn_addr, last_addr);
          if (!seen_first) begin
            seen_first = 1;
            chk(txn_addr == T_FADDR[v], tg, "R3 first addr", txn_addr, T_FADDR[v]);
            chk(txn_size == 8'(T_FSIZE[v]), tg, "R3 first size", 32'(txn_size), T_FSIZE[v]);
            chk(txn_lanes == T_FLANES[v], tg, "first lanes", txn_lanes, T_FLANES[v]);
          end
        end
        if ((v % 2 == 0) || (cyc % 3 != 1)) begin
          txn_grant = 1'b1;
          served    = served | txn_lanes;
          ntx++;
          fet      += int'(txn_size);
          last_addr = txn_addr;
          have_last = 1;
          stalled   = 0;
        end else begin
          txn_grant = 1'b0;
          stalled   = 1;
          s_addr = txn_addr; s_size = txn_size; s_lanes = txn_lanes;
        end
      end else begin
        txn_grant = 1'b0;
      end
      @(negedge clk);
    end
    if (!got_done) chk(1'b0, "R6", "done never seen", 0, 1);
    else chk(done == 1'b0, "R6", "done one cycle", 32'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_active = '0; txn_grant = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    chk(req_ready == 1'b1, "R8", "reset ready", 32'(req_ready), 1);
    chk(txn_valid == 1'b0, "R8", "reset txn_valid", 32'(txn_valid), 0);
    chk(done == 1'b0, "R8", "reset done", 32'(done), 0);
    for (int v = 0; v < NV; v++) run_vec(v);
    // Back-to-back: empty request right after a full one (R5, R6).
    run_vec(7);
    run_vec(0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule